// File: doc/BRIEF.md
# Mode-Reconfigurable Multi-Width Adder

This block is an adder datapath that is four lanes wide. It is built from two narrow adder slices, each one lane wide, and one wide slice that is two lanes wide and covers the upper half. A mode code chooses how the slices work together. They can act as one narrow add, two independent narrow adds, one add across the lower half, two independent half-width adds, or one add across the full width.

Slices that the chosen mode does not use are switched off. Their operands are forced to zero and their sum bits stay at zero, so they do not toggle. Each slice keeps its carry-out in a one-bit register. That register is routed back as carry-in through multiplexers that depend on the mode. This lets software chain a multi-word addition over several cycles, with each cycle adding the carry of the one before.

Inside a wider configuration, carries pass between slices combinationally in the same cycle. The sum output is combinational, so a new mode code takes effect in the cycle it is applied.

Top module: `mwadd_top`

## Requirements
- R1: The mode codes are one-hot on the 5-bit `mode_code` input:
  - 5'b00001: single narrow add.
  - 5'b00010: dual narrow adds.
  - 5'b00100: single half-width add.
  - 5'b01000: dual half-width adds.
  - 5'b10000: full-width add.
  - Any other value behaves exactly like 5'b00001.
- R2: In single narrow mode, sum bits [L-1:0] equal the low lane of a plus the low lane of b plus carry register C1, where L is the lane width. All higher sum bits are 0.
- R3: In dual narrow mode:
  - Lane 0 is a+b+C1.
  - Lane 1 (bits [2L-1:L]) is a+b+C2, with no carry passing from lane 0.
  - The upper half of the sum is 0.
- R4: In single half-width mode:
  - Bits [2L-1:0] are a+b+C2 over the lower half, with the lane-0 carry passed into lane 1 in the same cycle.
  - The upper half of the sum is 0.
- R5: In dual half-width mode, the lower half is a+b+C2 as in R4. The upper half (bits [4L-1:2L]) is a+b+C3, independent of the lower half.
- R6: In full-width mode, the whole sum is a+b+C3 modulo 2^(4L), with carries chained through all slices.
- R7: A slice that the mode does not use drives zeros on its sum bits and keeps its carry register unchanged.
- R8: On each rising clock edge, every slice in use loads its own carry-out into its carry register. The next add picks this carry up, which lets multi-word sums chain.
- R9: When `clr` is high at a clock edge, all three carry registers become 0. This takes priority over the load in R8.
- R10: While `rst_n` is low, all carry registers are 0.
- R11: A change of mode code affects the sum in the same cycle, and the mode may change on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the carry registers |
| clr | input | 1 | Synchronous clear of all carry registers |
| mode_code | input | 5 | One-hot configuration select |
| a_i | input | 4*LANE_W | First operand |
| b_i | input | 4*LANE_W | Second operand |
| sum_o | output | 4*LANE_W | Combinational sum, unused lanes zero |

## Verification
The bench builds the block with LANE_W set to 8, which makes the full datapath 32 bits wide. At that width a reference model using plain 64-bit integer arithmetic can cover every mode. Random operands then produce carry-outs from every slice often, so feedback, chaining, hold and clear are all exercised many times.

Directed steps push all-ones values through each configuration and then add zeros, so the stored carry shows up directly on the sum. A long random run changes the mode on every cycle, including undefined codes.

// File: rtl/mwadd_pkg.sv
package mwadd_pkg;

    localparam logic [4:0] MODE_S32  = 5'b00001;
    localparam logic [4:0] MODE_D32  = 5'b00010;
    localparam logic [4:0] MODE_S64  = 5'b00100;
    localparam logic [4:0] MODE_D64  = 5'b01000;
    localparam logic [4:0] MODE_W128 = 5'b10000;

    // eight decoded controls: three slice enables, five mux selects
    typedef struct packed {
        logic en_lo0;
        logic en_lo1;
        logic en_hi;
        logic fb_c1;    // lane-0 carry-in from C1
        logic fb_c2;    // lane-0 carry-in from C2
        logic fb_c3;    // lane-0 carry-in from C3
        logic chain_1;  // lane-1 carry-in from lane-0 carry-out
        logic chain_hi; // wide slice carry-in from lane-1 carry-out
    } ctrl_t;

    typedef struct packed {
        logic c1;
        logic c2;
        logic c3;
    } carry_t;

endpackage

// File: rtl/mwadd_decode.sv
module mwadd_decode
    import mwadd_pkg::*;
(
    input  logic [4:0] mode_code,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (mode_code)
            MODE_D32: begin
                ctrl.en_lo0 = 1'b1;
                ctrl.en_lo1 = 1'b1;
                ctrl.fb_c1  = 1'b1;
            end
            MODE_S64: begin
                ctrl.en_lo0  = 1'b1;
                ctrl.en_lo1  = 1'b1;
                ctrl.fb_c2   = 1'b1;
                ctrl.chain_1 = 1'b1;
            end
            MODE_D64: begin
                ctrl.en_lo0  = 1'b1;
                ctrl.en_lo1  = 1'b1;
                ctrl.en_hi   = 1'b1;
                ctrl.fb_c2   = 1'b1;
                ctrl.chain_1 = 1'b1;
            end
            MODE_W128: begin
                ctrl.en_lo0   = 1'b1;
                ctrl.en_lo1   = 1'b1;
                ctrl.en_hi    = 1'b1;
                ctrl.fb_c3    = 1'b1;
                ctrl.chain_1  = 1'b1;
                ctrl.chain_hi = 1'b1;
            end
            default: begin
                ctrl.en_lo0 = 1'b1;
                ctrl.fb_c1  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mwadd_slice.sv
module mwadd_slice #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic         cin,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] opa_g;
    logic [W-1:0] opb_g;
    logic         cin_g;
    logic [W:0]   raw;

    // operand isolation: an idle slice sees constant zeros
    always_comb begin
        opa_g = en ? a : '0;
        opb_g = en ? b : '0;
        cin_g = en & cin;
        raw   = {1'b0, opa_g} + {1'b0, opb_g} + {{W{1'b0}}, cin_g};
        sum   = raw[W-1:0];
        cout  = raw[W];
    end

endmodule

// File: rtl/mwadd_top.sv
module mwadd_top
    import mwadd_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [4:0]            mode_code,
    input  logic [4*LANE_W-1:0]   a_i,
    input  logic [4*LANE_W-1:0]   b_i,
    output logic [4*LANE_W-1:0]   sum_o
);

    localparam int WIDE_W  = 2 * LANE_W;
    localparam int TOTAL_W = 4 * LANE_W;

    ctrl_t  ctrl;
    carry_t cry_d, cry_q;

    logic [1:0]        lo_en;
    logic [1:0]        lo_cin;
    logic [1:0]        lo_cout;
    logic [WIDE_W-1:0] lo_sum;
    logic [WIDE_W-1:0] hi_sum;
    logic              hi_cin;
    logic              hi_cout;

    mwadd_decode u_dec (
        .mode_code (mode_code),
        .ctrl      (ctrl)
    );

    // carry-in steering
    always_comb begin
        lo_en[0]  = ctrl.en_lo0;
        lo_en[1]  = ctrl.en_lo1;
        lo_cin[0] = (ctrl.fb_c1 & cry_q.c1)
                  | (ctrl.fb_c2 & cry_q.c2)
                  | (ctrl.fb_c3 & cry_q.c3);
        lo_cin[1] = ctrl.chain_1  ? lo_cout[0] : cry_q.c2;
        hi_cin    = ctrl.chain_hi ? lo_cout[1] : cry_q.c3;
    end

    // the two narrow slices
    for (genvar gi = 0; gi < 2; gi++) begin : g_lo
        mwadd_slice #(.W(LANE_W)) u_slice (
            .en   (lo_en[gi]),
            .cin  (lo_cin[gi]),
            .a    (a_i[gi*LANE_W +: LANE_W]),
            .b    (b_i[gi*LANE_W +: LANE_W]),
            .sum  (lo_sum[gi*LANE_W +: LANE_W]),
            .cout (lo_cout[gi])
        );
    end

    // the wide upper slice
    mwadd_slice #(.W(WIDE_W)) u_hi (
        .en   (ctrl.en_hi),
        .cin  (hi_cin),
        .a    (a_i[TOTAL_W-1:WIDE_W]),
        .b    (b_i[TOTAL_W-1:WIDE_W]),
        .sum  (hi_sum),
        .cout (hi_cout)
    );

    assign sum_o = {hi_sum, lo_sum};

    // carry register next state
    always_comb begin
        cry_d = cry_q;
        if (clr) begin
            cry_d = '0;
        end else begin
            if (ctrl.en_lo0) cry_d.c1 = lo_cout[0];
            if (ctrl.en_lo1) cry_d.c2 = lo_cout[1];
            if (ctrl.en_hi)  cry_d.c3 = hi_cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cry_q <= '0;
        else        cry_q <= cry_d;
    end

endmodule

// File: rtl/mwadd_chk.sv
module mwadd_chk
    import mwadd_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic [4:0]          mode_code,
    input logic [4*LANE_W-1:0] a_i,
    input logic [4*LANE_W-1:0] b_i,
    input logic [4*LANE_W-1:0] sum_o,
    input carry_t              cry_q
);

    localparam int TW = 4 * LANE_W;

    logic           is_d32, is_s64, is_d64, is_w128, is_s32;
    logic [TW:0]    full;
    logic [LANE_W:0] lane0_d32;

    always_comb begin
        is_d32   = (mode_code == MODE_D32);
        is_s64   = (mode_code == MODE_S64);
        is_d64   = (mode_code == MODE_D64);
        is_w128  = (mode_code == MODE_W128);
        is_s32   = !(is_d32 || is_s64 || is_d64 || is_w128);
        full     = {1'b0, a_i} + {1'b0, b_i} + {{TW{1'b0}}, cry_q.c3};
        lane0_d32 = {1'b0, a_i[LANE_W-1:0]} + {1'b0, b_i[LANE_W-1:0]}
                  + {{LANE_W{1'b0}}, cry_q.c1};
    end

    // R7
    upper_idle_s32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_s32 |-> sum_o[TW-1:LANE_W] == '0);

    // R7
    c3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(is_d64 || is_w128) && !clr) |=> $stable(cry_q.c3));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cry_q == '0));

    // R6
    full_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_w128 |-> sum_o == full[TW-1:0]);

    // R3
    d32_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_d32 |-> sum_o[LANE_W-1:0] == lane0_d32[LANE_W-1:0]);

    // R8
    full_carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_w128 && !clr) |=> cry_q.c3 == $past(full[TW]));

endmodule

bind mwadd_top mwadd_chk #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .mode_code (mode_code),
    .a_i       (a_i),
    .b_i       (b_i),
    .sum_o     (sum_o),
    .cry_q     (cry_q)
);

// File: tb/sim_mwadd_top.sv
module sim_mwadd_top;

    localparam int W  = 8;
    localparam int TW = 4 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [4:0]    mode_code = 5'b00001;
    logic [TW-1:0] a_i = '0;
    logic [TW-1:0] b_i = '0;
    logic [TW-1:0] sum_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit m1 = 0, m2 = 0, m3 = 0;

    always #5 clk = ~clk;

    mwadd_top #(.LANE_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode_code(mode_code),
        .a_i(a_i), .b_i(b_i), .sum_o(sum_o)
    );

    function automatic longint unsigned fld(longint unsigned v, int lo, int w);
        return (v >> lo) & ((64'd1 << w) - 64'd1);
    endfunction

    function automatic void model(input logic [4:0] m, input longint unsigned a, b,
                                  input bit c1, c2, c3, output longint unsigned s,
                                  output bit n1, n2, n3);
        longint unsigned t0, t1, th;
        n1 = c1; n2 = c2; n3 = c3; s = 0;
        case (m)
            5'b00010: begin
                t0 = fld(a, 0, W) + fld(b, 0, W) + 64'(c1);
                t1 = fld(a, W, W) + fld(b, W, W) + 64'(c2);
                s  = fld(t0, 0, W) | (fld(t1, 0, W) << W);
                n1 = t0[W]; n2 = t1[W];
            end
            5'b00100, 5'b01000: begin
                t0 = fld(a, 0, W) + fld(b, 0, W) + 64'(c2);
                t1 = fld(a, 0, 2*W) + fld(b, 0, 2*W) + 64'(c2);
                s  = fld(t1, 0, 2*W);
                n1 = t0[W]; n2 = t1[2*W];
                if (m == 5'b01000) begin
                    th = fld(a, 2*W, 2*W) + fld(b, 2*W, 2*W) + 64'(c3);
                    s  = s | (fld(th, 0, 2*W) << (2*W));
                    n3 = th[2*W];
                end
            end
            5'b10000: begin
                t0 = fld(a, 0, W) + fld(b, 0, W) + 64'(c3);
                t1 = fld(a, 0, 2*W) + fld(b, 0, 2*W) + 64'(c3);
                th = fld(a, 0, 4*W) + fld(b, 0, 4*W) + 64'(c3);
                s  = fld(th, 0, 4*W);
                n1 = t0[W]; n2 = t1[2*W]; n3 = th[4*W];
            end
            default: begin
                t0 = fld(a, 0, W) + fld(b, 0, W) + 64'(c1);
                s  = fld(t0, 0, W);
                n1 = t0[W];
            end
        endcase
    endfunction

    task automatic check(input logic [TW-1:0] exp, input string tag);
        n_cmp++;
        if (sum_o !== exp) begin
            n_bad++;
            $display("FAIL %s: sum actual %h expected %h", tag, sum_o, exp);
        end
    endtask

    task automatic step(input logic [4:0] m, input logic [TW-1:0] a, b,
                        input logic c, input string tag);
        longint unsigned s;
        bit n1, n2, n3;
        @(negedge clk);
        mode_code = m; a_i = a; b_i = b; clr = c;
        #2;
        model(m, 64'(a), 64'(b), m1, m2, m3, s, n1, n2, n3);
        check(TW'(s), tag);
        @(posedge clk);
        if (c) begin m1 = 0; m2 = 0; m3 = 0; end
        else   begin m1 = n1; m2 = n2; m3 = n3; end
    endtask

    bit done = 0;

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] codes [8];
        codes = '{5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000,
                  5'b00000, 5'b00011, 5'b11111};
        repeat (3) @(negedge clk);
        #2;
        check('0, "R10 reset");                        // R10
        @(negedge clk);
        rst_n = 1'b1;

        step(5'b00001, 32'hAABB_CCFF, 32'h1122_3301, 0, "R2 s32 carry");
        step(5'b00001, 32'hFFFF_FF00, 32'h0, 0, "R8 s32 feedback");
        step(5'b00000, 32'hABCD_EF10, 32'h0000_0020, 0, "R1 undefined code");
        step(5'b00010, 32'h0000_FFFF, 32'h0000_0101, 0, "R3 d32 carries");
        step(5'b00010, 32'h0, 32'h0, 0, "R3 d32 own feedback");
        step(5'b00100, 32'hFF00_FFFF, 32'h0000_0001, 0, "R4 s64 chain");
        step(5'b00100, 32'h0, 32'h0, 0, "R4 s64 uses C2");
        step(5'b01000, 32'hFFFF_FFFF, 32'h0001_0001, 0, "R5 d64");
        step(5'b01000, 32'h0, 32'h0, 0, "R5 d64 feedback");
        step(5'b10000, 32'hFFFF_FFFF, 32'h0000_0001, 0, "R6 w128 chain");
        step(5'b00001, 32'h1234_5678, 32'h0, 0, "R7 s32 upper idle");
        step(5'b00010, 32'h1234_5678, 32'h1111_1111, 0, "R7 d32 upper idle");
        step(5'b10000, 32'h0, 32'h0, 0, "R7 C3 held then R8");
        step(5'b10000, 32'hFFFF_FFFF, 32'h0000_0001, 1, "R9 clear with carry");
        step(5'b10000, 32'h0, 32'h0, 0, "R9 carries cleared");
        step(5'b00010, 32'h0, 32'h0, 0, "R9 C1 C2 cleared");

        for (int i = 0; i < 3000; i++) begin
            step(codes[$urandom_range(0, 7)], TW'($urandom), TW'($urandom),
                 ($urandom_range(0, 15) == 0), "R11 random mode each cycle");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule